// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block is the command front end of a four-bank double-data-rate DRAM model. On each rising clock edge it samples chip select, the row strobe, the column strobe, write enable, a 2-bit bank address and a 13-bit address. It turns them into a single-cycle strobe for the decoded command, and it presents the target bank and the address fields that the array and mode logic further down need.

The decoder keeps an open or idle flag for each bank. It uses that state in two ways: to reject accesses that make no sense, and to pick the right low-power state when the clock enable falls. The same address bit, A10, has two meanings. On a precharge it selects whether every bank closes. On a read or write it requests auto-precharge. During a mode-register load, bank-address bit 0 selects the base or the extended register, and the address bus carries the opcode.

Every output is registered. A command sampled at edge k shows its effect on the outputs just after edge k.

Top module: `dram_cmd_front`

## Requirements
- R1: While reset is held and just after it, every bank is idle, the power state is run (0), and no strobe, illegal flag or CKE-error flag is high.
- R2: The command code {rasN,casN,weN} is sampled only on the rising edge, with chip select low. The codes are 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load, and 111 or 110 no strobe. The matching strobe is high for the one cycle after that edge.
- R3: A cycle in which chip select is sampled high gives no strobe and changes no bank state, whatever the other inputs are.
- R4: An activate to an idle bank opens that bank and shows the bank on tgtBank and the 13-bit row on rowAddr.
- R5: A read or write to an open bank shows addr[COL_W-1:0] on colAddr and addr[10] on autoPre. When addr[10] is 1, the bank is idle from the next cycle on.
- R6: A precharge with addr[10]=0 closes only the addressed bank. With addr[10]=1 it closes all banks and raises preAll.
- R7: A mode load raises mrsSel equal to ba[0] (0 base, 1 extended) and carries the opcode on rowAddr.
- R8: An activate to an open bank, or a read or write to an idle bank, raises illegal for one cycle, gives no strobe and leaves every bank flag unchanged.
- R9: In run state, CKE sampled low enters precharge power-down (1) if all banks are idle and active power-down (2) otherwise. The command of that cycle is not executed.
- R10: In run state, a refresh command sampled with CKE low enters self refresh (3) and gives no strobe.
- R11: In any low-power state, commands give no strobe. The first edge with CKE high returns to run (0) and still executes no command.
- R12: CKE sampled low at any of the BURST_CYCLES edges that follow an accepted read or write raises ckeErr for one cycle. A later drop does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address / opcode |
| actStb | output | 1 | Activate accepted |
| rdStb | output | 1 | Read accepted |
| wrStb | output | 1 | Write accepted |
| preStb | output | 1 | Precharge accepted |
| refStb | output | 1 | Refresh accepted |
| mrsStb | output | 1 | Mode load accepted |
| tgtBank | output | 2 | Bank of the last accepted command |
| rowAddr | output | 13 | Row address or mode opcode |
| colAddr | output | 10 | Column address |
| autoPre | output | 1 | Auto-precharge requested on read/write |
| preAll | output | 1 | Precharge applied to all banks |
| mrsSel | output | 1 | 0 base, 1 extended mode register |
| bankOpen | output | 4 | Open flag per bank |
| pwrState | output | 2 | 0 run, 1 precharge PD, 2 active PD, 3 self refresh |
| illegal | output | 1 | Rejected access pulse |
| ckeErr | output | 1 | CKE dropped during a burst |

## Verification
The bench builds the block with its defaults: four banks, a 10-bit column, A10 as the dual-use bit and a four-cycle burst window. The short burst window lets both sides of the CKE-error boundary be reached within a few cycles: a drop on the first edge after a read, and a drop after five idle edges. With four banks, the bench can open two banks and then tell a single-bank precharge from a precharge of all banks.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic refr;
    logic mrs;
  } cmdStb_t;

  typedef enum logic [1:0] {
    PWR_RUN    = 2'd0,
    PWR_PRE_PD = 2'd1,
    PWR_ACT_PD = 2'd2,
    PWR_SELF   = 2'd3
  } pwrState_t;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmdCode_t;

endpackage

// File: rtl/dram_cmd_ctrl.sv
module dram_cmd_ctrl
  import dram_cmd_pkg::*;
#(
  parameter int BANKS        = 4,
  parameter int BURST_CYCLES = 4,
  localparam int BA_W        = $clog2(BANKS),
  localparam int CNT_W       = $clog2(BURST_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [BA_W-1:0]  ba,
  input  logic             apBit,
  output cmdStb_t          stb,
  output logic [BANKS-1:0] bankOpen,
  output logic [1:0]       pwrState,
  output logic             illegal,
  output logic             ckeErr
);

  pwrState_t        pwrQ;
  cmdCode_t         code;
  logic [CNT_W-1:0] burstCnt;
  logic [BANKS-1:0] openNext;
  logic             running;
  logic             issue;
  logic             bankHit;
  logic             illegalNext;

  assign code     = cmdCode_t'({rasN, casN, weN});
  assign running  = (pwrQ == PWR_RUN);
  assign issue    = running && cke && !csN;
  assign bankHit  = bankOpen[ba];
  assign pwrState = pwrQ;

  always_comb begin
    stb         = '0;
    illegalNext = 1'b0;
    if (issue) begin
      unique case (code)
        CMD_ACT: if (bankHit) illegalNext = 1'b1; else stb.act = 1'b1;
        CMD_RD:  if (!bankHit) illegalNext = 1'b1; else stb.rd = 1'b1;
        CMD_WR:  if (!bankHit) illegalNext = 1'b1; else stb.wr = 1'b1;
        CMD_PRE: stb.pre  = 1'b1;
        CMD_REF: stb.refr = 1'b1;
        CMD_MRS: stb.mrs  = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(g));
    assign openNext[g] =
        (stb.act && sel)                      ? 1'b1 :
        ((stb.rd || stb.wr) && apBit && sel)  ? 1'b0 :
        (stb.pre && (apBit || sel))           ? 1'b0 :
                                                bankOpen[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrQ     <= PWR_RUN;
      bankOpen <= '0;
      burstCnt <= '0;
      illegal  <= 1'b0;
      ckeErr   <= 1'b0;
    end else if (running && cke) begin
      bankOpen <= openNext;
      illegal  <= illegalNext;
      ckeErr   <= 1'b0;
      if (stb.rd || stb.wr)    burstCnt <= CNT_W'(BURST_CYCLES);
      else if (burstCnt != 0)  burstCnt <= burstCnt - 1'b1;
    end else if (running) begin
      illegal  <= 1'b0;
      ckeErr   <= (burstCnt != 0);
      burstCnt <= '0;
      if (!csN && code == CMD_REF) pwrQ <= PWR_SELF;
      else if (|bankOpen)          pwrQ <= PWR_ACT_PD;
      else                         pwrQ <= PWR_PRE_PD;
    end else begin
      illegal <= 1'b0;
      ckeErr  <= 1'b0;
      if (cke) pwrQ <= PWR_RUN;
    end
  end

endmodule

// File: rtl/dram_cmd_dp.sv
module dram_cmd_dp
  import dram_cmd_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmdStb_t          stb,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  output logic             actStb,
  output logic             rdStb,
  output logic             wrStb,
  output logic             preStb,
  output logic             refStb,
  output logic             mrsStb,
  output logic [BA_W-1:0]  tgtBank,
  output logic [ROW_W-1:0] rowAddr,
  output logic [COL_W-1:0] colAddr,
  output logic             autoPre,
  output logic             preAll,
  output logic             mrsSel
);

  logic anyStb;
  assign anyStb = |stb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {actStb, rdStb, wrStb, preStb, refStb, mrsStb} <= '0;
      tgtBank <= '0;
      rowAddr <= '0;
      colAddr <= '0;
      autoPre <= 1'b0;
      preAll  <= 1'b0;
      mrsSel  <= 1'b0;
    end else begin
      {actStb, rdStb, wrStb, preStb, refStb, mrsStb} <= stb;
      autoPre <= (stb.rd || stb.wr) && addr[AP_BIT];
      preAll  <= stb.pre && addr[AP_BIT];
      mrsSel  <= stb.mrs && ba[0];
      if (anyStb) begin
        tgtBank <= ba;
        rowAddr <= addr;
        colAddr <= addr[COL_W-1:0];
      end
    end
  end

endmodule

// File: rtl/dram_cmd_front.sv
module dram_cmd_front
  import dram_cmd_pkg::*;
#(
  parameter int BANKS        = 4,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int AP_BIT       = 10,
  parameter int BURST_CYCLES = 4,
  localparam int BA_W        = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  output logic             actStb,
  output logic             rdStb,
  output logic             wrStb,
  output logic             preStb,
  output logic             refStb,
  output logic             mrsStb,
  output logic [BA_W-1:0]  tgtBank,
  output logic [ROW_W-1:0] rowAddr,
  output logic [COL_W-1:0] colAddr,
  output logic             autoPre,
  output logic             preAll,
  output logic             mrsSel,
  output logic [BANKS-1:0] bankOpen,
  output logic [1:0]       pwrState,
  output logic             illegal,
  output logic             ckeErr
);

  cmdStb_t stb;

  dram_cmd_ctrl #(.BANKS(BANKS), .BURST_CYCLES(BURST_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .apBit(addr[AP_BIT]), .stb(stb), .bankOpen(bankOpen),
    .pwrState(pwrState), .illegal(illegal), .ckeErr(ckeErr)
  );

  dram_cmd_dp #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ba(ba), .addr(addr),
    .actStb(actStb), .rdStb(rdStb), .wrStb(wrStb), .preStb(preStb),
    .refStb(refStb), .mrsStb(mrsStb), .tgtBank(tgtBank), .rowAddr(rowAddr),
    .colAddr(colAddr), .autoPre(autoPre), .preAll(preAll), .mrsSel(mrsSel)
  );

endmodule

// File: rtl/dram_cmd_checker.sv
module dram_cmd_checker #(
  parameter int BANKS = 4,
  localparam int BA_W = $clog2(BANKS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             actStb,
  input logic             rdStb,
  input logic             wrStb,
  input logic             preStb,
  input logic             refStb,
  input logic             mrsStb,
  input logic             preAll,
  input logic [BA_W-1:0]  tgtBank,
  input logic [BANKS-1:0] bankOpen,
  input logic [1:0]       pwrState,
  input logic             illegal,
  input logic             ckeErr
);

  logic [5:0] stbs;
  assign stbs = {actStb, rdStb, wrStb, preStb, refStb, mrsStb};

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbs));

  p_cs_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (stbs == '0));

  p_act_opens_r4: assert property (@(posedge clk) disable iff (!rstN)
    actStb |-> bankOpen[tgtBank]);

  p_pre_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    (preStb && preAll) |-> (bankOpen == '0));

  p_illegal_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (bankOpen == $past(bankOpen)));

  p_lowpower_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'd0) |-> (stbs == '0));

  p_cke_err_state_r12: assert property (@(posedge clk) disable iff (!rstN)
    ckeErr |-> (pwrState != 2'd0));

endmodule

bind dram_cmd_front dram_cmd_checker #(.BANKS(BANKS)) u_chk (.*);

// File: tb/tb_dram_cmd_front.sv
module tb_dram_cmd_front;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                         C_ACT = 3'b011, C_WR = 3'b100, C_RD = 3'b101,
                         C_NOP = 3'b111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic actStb, rdStb, wrStb, preStb, refStb, mrsStb;
  logic [1:0] tgtBank;
  logic [12:0] rowAddr;
  logic [9:0] colAddr;
  logic autoPre, preAll, mrsSel;
  logic [3:0] bankOpen;
  logic [1:0] pwrState;
  logic illegal, ckeErr;

  always #4 clk = ~clk;

  dram_cmd_front dut (.*);

  typedef struct {
    string       req;
    logic [5:0]  stbs;
    logic        addrChk;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [9:0]  col;
    logic        ap, pa, ms;
    logic [3:0]  open;
    logic [1:0]  pwr;
    logic        ill, cerr;
  } exp_t;

  exp_t q[$];
  int errors = 0, checks = 0;
  bit done = 0;

  logic [3:0] mOpen = '0;
  int mPwr = 0, mBurst = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic cs, input logic [2:0] c,
                      input logic [1:0] b, input logic [12:0] a, input string req);
    exp_t e;
    e.req = req; e.stbs = '0; e.addrChk = 0; e.bank = b; e.row = a;
    e.col = a[9:0]; e.ap = 0; e.pa = 0; e.ms = 0; e.ill = 0; e.cerr = 0;
    if (mPwr == 0 && k) begin
      if (!cs) begin
        case (c)
          C_ACT: if (mOpen[b]) e.ill = 1; else begin mOpen[b] = 1; e.stbs = 6'b100000; end
          C_RD, C_WR: if (!mOpen[b]) e.ill = 1; else begin
            e.stbs = (c == C_RD) ? 6'b010000 : 6'b001000;
            e.ap = a[10];
            if (a[10]) mOpen[b] = 0;
          end
          C_PRE: begin
            e.stbs = 6'b000100; e.pa = a[10];
            if (a[10]) mOpen = '0; else mOpen[b] = 0;
          end
          C_REF: e.stbs = 6'b000010;
          C_MRS: begin e.stbs = 6'b000001; e.ms = b[0]; end
          default: ;
        endcase
      end
      e.addrChk = (e.stbs != 0);
      if (e.stbs[4] || e.stbs[3]) mBurst = 4;
      else if (mBurst > 0) mBurst--;
    end else if (mPwr == 0) begin
      e.cerr = (mBurst != 0);
      mBurst = 0;
      mPwr = (!cs && c == C_REF) ? 3 : ((mOpen != 0) ? 2 : 1);
    end else if (k) begin
      mPwr = 0;
    end
    e.open = mOpen; e.pwr = 2'(mPwr);
    @(negedge clk);
    cke = k; csN = cs; {rasN, casN, weN} = c; ba = b; addr = a;
    @(posedge clk);
    #2;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.req, "strobes", {actStb, rdStb, wrStb, preStb, refStb, mrsStb}, e.stbs);
        chk(e.req, "bankOpen", bankOpen, e.open);
        chk(e.req, "pwrState", pwrState, e.pwr);
        chk(e.req, "illegal", illegal, e.ill);
        chk(e.req, "ckeErr", ckeErr, e.cerr);
        chk(e.req, "autoPre", autoPre, e.ap);
        chk(e.req, "preAll", preAll, e.pa);
        chk(e.req, "mrsSel", mrsSel, e.ms);
        if (e.addrChk) begin
          chk(e.req, "tgtBank", tgtBank, e.bank);
          chk(e.req, "rowAddr", rowAddr, e.row);
          chk(e.req, "colAddr", colAddr, e.col);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "strobes", {actStb, rdStb, wrStb, preStb, refStb, mrsStb}, 0);
    chk("R1", "bankOpen", bankOpen, 0);
    chk("R1", "pwrState", pwrState, 0);
    chk("R1", "flags", {illegal, ckeErr}, 0);
    rstN = 1'b1;
    step(1, 0, C_NOP, 0, 0, "R2");
    step(1, 0, C_ACT, 1, 13'h1ABC, "R4");
    step(1, 0, C_ACT, 1, 13'h0123, "R8");
    step(1, 0, C_RD,  2, 13'h0055, "R8");
    step(1, 0, C_WR,  3, 13'h0055, "R8");
    step(1, 0, C_RD,  1, 13'h0155, "R5");
    step(0, 0, C_NOP, 0, 0, "R12");          // drop during burst -> ckeErr, R9 active PD
    step(0, 0, C_ACT, 0, 13'h0001, "R11");   // ignored while powered down
    step(1, 0, C_ACT, 0, 13'h0002, "R11");   // exit edge, command ignored
    step(1, 0, C_WR,  1, 13'h07AA, "R5");    // auto-precharge closes bank 1
    repeat (5) step(1, 0, C_NOP, 0, 0, "R2");
    step(0, 1, C_NOP, 0, 0, "R9");           // all idle -> precharge PD, no ckeErr
    step(1, 1, C_NOP, 0, 0, "R11");
    step(1, 0, C_ACT, 0, 13'h0F00, "R4");
    step(1, 0, C_ACT, 3, 13'h1001, "R4");
    step(1, 0, C_PRE, 0, 13'h0000, "R6");    // single bank
    step(1, 0, C_ACT, 2, 13'h0777, "R4");
    step(1, 0, C_PRE, 1, 13'h0400, "R6");    // all banks
    step(1, 1, C_ACT, 2, 13'h0033, "R3");    // masked by chip select
    step(1, 1, C_MRS, 1, 13'h0033, "R3");
    step(1, 0, C_MRS, 1, 13'h0042, "R7");
    step(1, 0, C_MRS, 0, 13'h0162, "R7");
    step(1, 0, C_REF, 0, 0, "R2");
    step(1, 0, 3'b110, 0, 0, "R2");
    step(0, 0, C_REF, 0, 0, "R10");          // self refresh
    step(0, 0, C_ACT, 1, 13'h0010, "R11");
    step(1, 0, C_NOP, 0, 0, "R11");
    step(1, 0, C_ACT, 2, 13'h0ABC, "R4");
    step(0, 0, C_NOP, 0, 0, "R9");           // bank open -> active PD
    step(1, 0, C_NOP, 0, 0, "R11");
    step(1, 0, C_RD, 2, 13'h0003, "R5");
    repeat (3) step(1, 0, C_NOP, 0, 0, "R2");
    step(0, 0, C_NOP, 0, 0, "R12");          // fourth edge after read: still flagged
    step(1, 0, C_NOP, 0, 0, "R11");
    repeat (2) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule